// File: doc/BRIEF.md
# Bidirectional Ring Stop

This block is one node of a bidirectional on-die ring that links cores, cache slices and a system agent. Four physically separate rings (request, snoop, acknowledge, data) run through every stop, and each has its own clockwise and counter-clockwise link pair. Each ring is arbitrated by itself. A stop removes flits addressed to its own ID onto a local eject port, and forwards every other flit one stop per clock in the direction it was travelling. When a slot is free it places local traffic onto the ring in the direction with fewer hops to the destination.

Arbitration is fully distributed. Traffic already on the ring beats local injection. A per-direction wait counter guarantees that a starved injector eventually gets in: the forced injection pushes the through flit into a one-entry holding slot instead of dropping it. Messages are not kept in order. Stops are chained so that the clockwise output of stop k feeds the clockwise input of stop k+1 (mod NSTOPS), and the counter-clockwise output of stop k feeds stop k-1.

Top module: `ring_stop`

## Requirements
- R1: Ring index 0 is request, 1 snoop, 2 acknowledge and 3 data. Each ring has its own inputs, outputs, inject ready and eject port, and traffic or blocking on one ring never changes another ring's behaviour.
- R2: A flit arriving on either input with destination equal to STOP_ID appears on the eject port of its arrival direction (ej_cw_* or ej_ccw_*) one cycle later, with its payload, and is not forwarded.
- R3: A flit arriving with any other destination leaves on the output of the same direction one cycle later, with destination and payload unchanged.
- R4: The clockwise distance is (dst - STOP_ID) mod NSTOPS. A message goes clockwise when that distance is no more than NSTOPS minus it, so ties and self-addressed messages go clockwise. Otherwise it goes counter-clockwise.
- R5: inj_rdy is high only when the chosen direction's outgoing slot is empty this cycle, meaning no through flit and no held flit. Through traffic wins otherwise, and an accepted flit leaves on that output one cycle later.
- R6: A slot emptied by a local ejection may be used for injection in the same cycle.
- R7: After STARVE_LIM (default 8) consecutive cycles with a blocked inject request in one direction, the next cycle accepts the injection. The through flit of that cycle goes into a holding slot and is not lost.
- R8: While the holding slot is occupied, its flit is sent out next and the arriving through flit takes its place. Injection in that direction is refused until the slot is empty, and the stream leaves in arrival order.
- R9: After reset all output and eject valids are low, and on an idle ring inj_rdy is high.
- R10: Payload bits at or above a ring's configured width (REQ_W, SNP_W, ACK_W, DAT_W) are zero on that ring's outputs and eject ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_in_vld | input | 4 | Clockwise arriving flit valid, per ring |
| cw_in_dst | input | 4 x IDW | Clockwise arriving destination ID |
| cw_in_pld | input | 4 x DW | Clockwise arriving payload |
| ccw_in_vld | input | 4 | Counter-clockwise arriving valid |
| ccw_in_dst | input | 4 x IDW | Counter-clockwise arriving destination |
| ccw_in_pld | input | 4 x DW | Counter-clockwise arriving payload |
| inj_vld | input | 4 | Local inject request, per ring |
| inj_dst | input | 4 x IDW | Inject destination ID |
| inj_pld | input | 4 x DW | Inject payload |
| inj_rdy | output | 4 | Inject accepted this cycle when inj_vld is high |
| cw_out_vld | output | 4 | Clockwise departing valid (registered) |
| cw_out_dst | output | 4 x IDW | Clockwise departing destination |
| cw_out_pld | output | 4 x DW | Clockwise departing payload |
| ccw_out_vld | output | 4 | Counter-clockwise departing valid |
| ccw_out_dst | output | 4 x IDW | Counter-clockwise departing destination |
| ccw_out_pld | output | 4 x DW | Counter-clockwise departing payload |
| ej_cw_vld | output | 4 | Ejected flit from the clockwise input |
| ej_cw_pld | output | 4 x DW | Its payload |
| ej_ccw_vld | output | 4 | Ejected flit from the counter-clockwise input |
| ej_ccw_pld | output | 4 x DW | Its payload |

## Verification
The bench builds the stop with NSTOPS = 8 and STOP_ID = 2, with the default widths and a wait limit of 8. An even ring size makes a 4-hop tie reachable (destination 6), and a stop ID above zero makes the modulo wrap visible for destinations 0 and 1. The default limit gives a starvation window short enough to stream through completely. That window shows the forced slot, the holding slot being refilled three times and its final drain. The full 256-bit data ring sits next to the 16-bit and 40-bit rings, so both wide payload transport and masking of the upper bits can be seen.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

  localparam int NRINGS   = 4;
  localparam int RING_REQ = 0;
  localparam int RING_SNP = 1;
  localparam int RING_ACK = 2;
  localparam int RING_DAT = 3;

  // hops needed when travelling clockwise from 'here' to 'dst'
  function automatic int cw_hops(input int dst, input int here, input int nstops);
    return (dst - here + nstops) % nstops;
  endfunction

  // clockwise wins ties
  function automatic logic prefer_cw(input int dst, input int here, input int nstops);
    int d;
    d = cw_hops(dst, here, nstops);
    return (d <= nstops - d);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rs_dir_slot.sv
module rs_dir_slot #(
  parameter int W    = 64,
  parameter int IDW  = 3,
  parameter int HERE = 0,
  parameter int LIM  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic [IDW-1:0] in_dst,
  input  logic [W-1:0]   in_pld,
  input  logic           want,
  input  logic [IDW-1:0] inj_dst,
  input  logic [W-1:0]   inj_pld,
  output logic           can,
  output logic           out_vld,
  output logic [IDW-1:0] out_dst,
  output logic [W-1:0]   out_pld,
  output logic           ej_vld,
  output logic [W-1:0]   ej_pld
);

  localparam int             CNTW  = $clog2(LIM + 1);
  localparam logic [IDW-1:0] MY_ID = IDW'(HERE);
  localparam logic [CNTW-1:0] CLIM = CNTW'(LIM);

  logic            is_local, thru_vld, slot_free, forced, take;
  logic            hold_vld;
  logic [IDW-1:0]  hold_dst;
  logic [W-1:0]    hold_pld;
  logic [CNTW-1:0] wait_cnt;

  always_comb begin
    is_local  = in_vld && (in_dst == MY_ID);
    thru_vld  = in_vld && !is_local;
    slot_free = !hold_vld && !thru_vld;
    forced    = !hold_vld && (wait_cnt == CLIM);
    can       = slot_free || forced;
    take      = want && can;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_dst  <= '0;
      out_pld  <= '0;
      hold_vld <= 1'b0;
      hold_dst <= '0;
      hold_pld <= '0;
      ej_vld   <= 1'b0;
      ej_pld   <= '0;
      wait_cnt <= '0;
    end else begin
      ej_vld <= is_local;
      ej_pld <= in_pld;
      if (take) begin
        out_vld  <= 1'b1;
        out_dst  <= inj_dst;
        out_pld  <= inj_pld;
        hold_vld <= thru_vld;
        hold_dst <= in_dst;
        hold_pld <= in_pld;
      end else if (hold_vld) begin
        out_vld  <= 1'b1;
        out_dst  <= hold_dst;
        out_pld  <= hold_pld;
        hold_vld <= thru_vld;
        hold_dst <= in_dst;
        hold_pld <= in_pld;
      end else begin
        out_vld <= thru_vld;
        out_dst <= in_dst;
        out_pld <= in_pld;
      end
      if (!want || take)
        wait_cnt <= '0;
      else if (wait_cnt != CLIM)
        wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R2
  eject_local_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_dst == MY_ID) |=> (ej_vld && ej_pld == $past(in_pld)));

  // R3
  pass_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_dst != MY_ID && !hold_vld && !(want && can))
      |=> (out_vld && out_dst == $past(in_dst) && out_pld == $past(in_pld)));

  // R5
  inject_place_chk: assert property (@(posedge clk) disable iff (rst)
    (want && can) |=> (out_vld && out_pld == $past(inj_pld)));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= CLIM);

  // R8
  hold_first_chk: assert property (@(posedge clk) disable iff (rst)
    hold_vld |=> (out_vld && out_pld == $past(hold_pld)));

  // R8
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    hold_vld |-> !can);

endmodule

// File: rtl/rs_lane.sv
module rs_lane
  import ring_stop_pkg::*;
#(
  parameter int W    = 64,
  parameter int NS   = 8,
  parameter int IDW  = 3,
  parameter int HERE = 0,
  parameter int LIM  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cw_in_vld,
  input  logic [IDW-1:0] cw_in_dst,
  input  logic [W-1:0]   cw_in_pld,
  input  logic           ccw_in_vld,
  input  logic [IDW-1:0] ccw_in_dst,
  input  logic [W-1:0]   ccw_in_pld,
  input  logic           inj_vld,
  input  logic [IDW-1:0] inj_dst,
  input  logic [W-1:0]   inj_pld,
  output logic           inj_rdy,
  output logic           cw_out_vld,
  output logic [IDW-1:0] cw_out_dst,
  output logic [W-1:0]   cw_out_pld,
  output logic           ccw_out_vld,
  output logic [IDW-1:0] ccw_out_dst,
  output logic [W-1:0]   ccw_out_pld,
  output logic           ej_cw_vld,
  output logic [W-1:0]   ej_cw_pld,
  output logic           ej_ccw_vld,
  output logic [W-1:0]   ej_ccw_pld
);

  logic go_cw, want_cw, want_ccw, can_cw, can_ccw;

  always_comb begin
    go_cw    = prefer_cw(int'(inj_dst), HERE, NS);
    want_cw  = inj_vld && go_cw;
    want_ccw = inj_vld && !go_cw;
    inj_rdy  = go_cw ? can_cw : can_ccw;
  end

  rs_dir_slot #(.W(W), .IDW(IDW), .HERE(HERE), .LIM(LIM)) i_cw_slot (
    .clk(clk), .rst(rst),
    .in_vld(cw_in_vld), .in_dst(cw_in_dst), .in_pld(cw_in_pld),
    .want(want_cw), .inj_dst(inj_dst), .inj_pld(inj_pld),
    .can(can_cw),
    .out_vld(cw_out_vld), .out_dst(cw_out_dst), .out_pld(cw_out_pld),
    .ej_vld(ej_cw_vld), .ej_pld(ej_cw_pld)
  );

  rs_dir_slot #(.W(W), .IDW(IDW), .HERE(HERE), .LIM(LIM)) i_ccw_slot (
    .clk(clk), .rst(rst),
    .in_vld(ccw_in_vld), .in_dst(ccw_in_dst), .in_pld(ccw_in_pld),
    .want(want_ccw), .inj_dst(inj_dst), .inj_pld(inj_pld),
    .can(can_ccw),
    .out_vld(ccw_out_vld), .out_dst(ccw_out_dst), .out_pld(ccw_out_pld),
    .ej_vld(ej_ccw_vld), .ej_pld(ej_ccw_pld)
  );

  // R4: an accepted flit with the short way clockwise leaves clockwise
  dir_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_vld && inj_rdy && (2 * ((int'(inj_dst) + NS - HERE) % NS) <= NS))
      |=> (cw_out_vld && cw_out_dst == $past(inj_dst) && cw_out_pld == $past(inj_pld)));

endmodule

// File: rtl/ring_stop.sv
module ring_stop
  import ring_stop_pkg::*;
#(
  parameter int NSTOPS     = 8,
  parameter int STOP_ID    = 0,
  parameter int REQ_W      = 72,
  parameter int SNP_W      = 40,
  parameter int ACK_W      = 16,
  parameter int DAT_W      = 256,
  parameter int STARVE_LIM = 8,
  parameter int IDW        = $clog2(NSTOPS),
  parameter int DW         = max2(max2(REQ_W, SNP_W), max2(ACK_W, DAT_W))
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NRINGS-1:0]            cw_in_vld,
  input  logic [NRINGS-1:0][IDW-1:0]   cw_in_dst,
  input  logic [NRINGS-1:0][DW-1:0]    cw_in_pld,
  input  logic [NRINGS-1:0]            ccw_in_vld,
  input  logic [NRINGS-1:0][IDW-1:0]   ccw_in_dst,
  input  logic [NRINGS-1:0][DW-1:0]    ccw_in_pld,
  input  logic [NRINGS-1:0]            inj_vld,
  input  logic [NRINGS-1:0][IDW-1:0]   inj_dst,
  input  logic [NRINGS-1:0][DW-1:0]    inj_pld,
  output logic [NRINGS-1:0]            inj_rdy,
  output logic [NRINGS-1:0]            cw_out_vld,
  output logic [NRINGS-1:0][IDW-1:0]   cw_out_dst,
  output logic [NRINGS-1:0][DW-1:0]    cw_out_pld,
  output logic [NRINGS-1:0]            ccw_out_vld,
  output logic [NRINGS-1:0][IDW-1:0]   ccw_out_dst,
  output logic [NRINGS-1:0][DW-1:0]    ccw_out_pld,
  output logic [NRINGS-1:0]            ej_cw_vld,
  output logic [NRINGS-1:0][DW-1:0]    ej_cw_pld,
  output logic [NRINGS-1:0]            ej_ccw_vld,
  output logic [NRINGS-1:0][DW-1:0]    ej_ccw_pld
);

  function automatic int ring_width(input int r);
    case (r)
      RING_REQ: return REQ_W;
      RING_SNP: return SNP_W;
      RING_ACK: return ACK_W;
      default:  return DAT_W;
    endcase
  endfunction

  for (genvar r = 0; r < NRINGS; r++) begin : g_ring
    localparam int          LW   = ring_width(r);
    localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - LW);

    rs_lane #(
      .W(DW), .NS(NSTOPS), .IDW(IDW), .HERE(STOP_ID), .LIM(STARVE_LIM)
    ) i_lane (
      .clk(clk), .rst(rst),
      .cw_in_vld(cw_in_vld[r]), .cw_in_dst(cw_in_dst[r]), .cw_in_pld(cw_in_pld[r] & MASK),
      .ccw_in_vld(ccw_in_vld[r]), .ccw_in_dst(ccw_in_dst[r]), .ccw_in_pld(ccw_in_pld[r] & MASK),
      .inj_vld(inj_vld[r]), .inj_dst(inj_dst[r]), .inj_pld(inj_pld[r] & MASK),
      .inj_rdy(inj_rdy[r]),
      .cw_out_vld(cw_out_vld[r]), .cw_out_dst(cw_out_dst[r]), .cw_out_pld(cw_out_pld[r]),
      .ccw_out_vld(ccw_out_vld[r]), .ccw_out_dst(ccw_out_dst[r]), .ccw_out_pld(ccw_out_pld[r]),
      .ej_cw_vld(ej_cw_vld[r]), .ej_cw_pld(ej_cw_pld[r]),
      .ej_ccw_vld(ej_ccw_vld[r]), .ej_ccw_pld(ej_ccw_pld[r])
    );

    // R10
    width_mask_chk: assert property (@(posedge clk) disable iff (rst)
      ((cw_out_pld[r] & ~MASK) == '0) && ((ccw_out_pld[r] & ~MASK) == '0));
  end

endmodule

// File: tb/test_ring_stop.sv
module test_ring_stop;

  localparam int NR  = 4;
  localparam int NS  = 8;
  localparam int ID  = 2;
  localparam int IDW = 3;
  localparam int DW  = 256;

  logic clk, rst;
  logic [NR-1:0]          cw_in_vld, ccw_in_vld, inj_vld, inj_rdy;
  logic [NR-1:0][IDW-1:0] cw_in_dst, ccw_in_dst, inj_dst;
  logic [NR-1:0][DW-1:0]  cw_in_pld, ccw_in_pld, inj_pld;
  logic [NR-1:0]          cw_out_vld, ccw_out_vld, ej_cw_vld, ej_ccw_vld;
  logic [NR-1:0][IDW-1:0] cw_out_dst, ccw_out_dst;
  logic [NR-1:0][DW-1:0]  cw_out_pld, ccw_out_pld, ej_cw_pld, ej_ccw_pld;

  int n_chk = 0;
  int n_fail = 0;

  ring_stop #(.NSTOPS(NS), .STOP_ID(ID)) i_ring_stop (
    .clk(clk), .rst(rst),
    .cw_in_vld(cw_in_vld), .cw_in_dst(cw_in_dst), .cw_in_pld(cw_in_pld),
    .ccw_in_vld(ccw_in_vld), .ccw_in_dst(ccw_in_dst), .ccw_in_pld(ccw_in_pld),
    .inj_vld(inj_vld), .inj_dst(inj_dst), .inj_pld(inj_pld), .inj_rdy(inj_rdy),
    .cw_out_vld(cw_out_vld), .cw_out_dst(cw_out_dst), .cw_out_pld(cw_out_pld),
    .ccw_out_vld(ccw_out_vld), .ccw_out_dst(ccw_out_dst), .ccw_out_pld(ccw_out_pld),
    .ej_cw_vld(ej_cw_vld), .ej_cw_pld(ej_cw_pld),
    .ej_ccw_vld(ej_ccw_vld), .ej_ccw_pld(ej_ccw_pld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cw_in_vld = '0;  cw_in_dst = '0;  cw_in_pld = '0;
    ccw_in_vld = '0; ccw_in_dst = '0; ccw_in_pld = '0;
    inj_vld = '0;    inj_dst = '0;    inj_pld = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    idle();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(cw_out_vld == '0 && ccw_out_vld == '0, "R9 ring outputs idle", DW'({cw_out_vld, ccw_out_vld}), '0);
    chk(ej_cw_vld == '0 && ej_ccw_vld == '0, "R9 eject idle", DW'({ej_cw_vld, ej_ccw_vld}), '0);
    chk(inj_rdy == 4'hF, "R9 inject ready on idle ring", DW'(inj_rdy), DW'(4'hF));
  endtask

  task automatic t_pass();
    idle();
    cw_in_vld[0] = 1'b1;  cw_in_dst[0] = 3'd5;  cw_in_pld[0] = DW'(72'h11_2233_4455);
    ccw_in_vld[0] = 1'b1; ccw_in_dst[0] = 3'd7; ccw_in_pld[0] = DW'(72'h66_7788);
    tick();
    chk(cw_out_vld[0] && cw_out_dst[0] == 3'd5 && cw_out_pld[0] == DW'(72'h11_2233_4455),
        "R3 clockwise pass", cw_out_pld[0], DW'(72'h11_2233_4455));
    chk(ccw_out_vld[0] && ccw_out_dst[0] == 3'd7 && ccw_out_pld[0] == DW'(72'h66_7788),
        "R3 counter-clockwise pass", ccw_out_pld[0], DW'(72'h66_7788));
    chk(ej_cw_vld[0] == 1'b0 && ej_ccw_vld[0] == 1'b0, "R3 no eject of through flit",
        DW'({ej_cw_vld[0], ej_ccw_vld[0]}), '0);
    idle(); tick();
  endtask

  task automatic t_eject();
    idle();
    cw_in_vld[0] = 1'b1;  cw_in_dst[0] = 3'(ID);  cw_in_pld[0] = DW'(32'hCAFE_0001);
    ccw_in_vld[0] = 1'b1; ccw_in_dst[0] = 3'(ID); ccw_in_pld[0] = DW'(32'hCAFE_0002);
    tick();
    chk(ej_cw_vld[0] && ej_cw_pld[0] == DW'(32'hCAFE_0001), "R2 eject from clockwise",
        ej_cw_pld[0], DW'(32'hCAFE_0001));
    chk(ej_ccw_vld[0] && ej_ccw_pld[0] == DW'(32'hCAFE_0002), "R2 eject from counter-clockwise",
        ej_ccw_pld[0], DW'(32'hCAFE_0002));
    chk(!cw_out_vld[0] && !ccw_out_vld[0], "R2 ejected flit not forwarded",
        DW'({cw_out_vld[0], ccw_out_vld[0]}), '0);
    idle(); tick();
  endtask

  task automatic t_dir_one(input int dst, input bit exp_cw);
    idle();
    inj_vld[0] = 1'b1; inj_dst[0] = 3'(dst); inj_pld[0] = DW'(64'hD1D0_0000 + dst);
    #1;
    chk(inj_rdy[0] == 1'b1, "R4 inject ready on empty ring", DW'(inj_rdy[0]), DW'(1));
    tick();
    chk(cw_out_vld[0] == exp_cw && ccw_out_vld[0] == !exp_cw, "R4 direction choice",
        DW'({cw_out_vld[0], ccw_out_vld[0]}), DW'({exp_cw, !exp_cw}));
    if (exp_cw)
      chk(cw_out_pld[0] == DW'(64'hD1D0_0000 + dst), "R4 clockwise payload",
          cw_out_pld[0], DW'(64'hD1D0_0000 + dst));
    else
      chk(ccw_out_pld[0] == DW'(64'hD1D0_0000 + dst), "R4 counter-clockwise payload",
          ccw_out_pld[0], DW'(64'hD1D0_0000 + dst));
    idle(); tick();
  endtask

  task automatic t_dir();
    t_dir_one(3, 1'b1);  // 1 hop clockwise
    t_dir_one(0, 1'b0);  // 6 vs 2
    t_dir_one(6, 1'b1);  // tie 4 vs 4
    t_dir_one(7, 1'b0);  // 5 vs 3
    t_dir_one(1, 1'b0);  // 7 vs 1 across the wrap
    t_dir_one(ID, 1'b1); // self-addressed
  endtask

  task automatic t_block();
    idle();
    cw_in_vld[0] = 1'b1; cw_in_dst[0] = 3'd5; cw_in_pld[0] = DW'(16'hEEE1);
    inj_vld[0] = 1'b1;   inj_dst[0] = 3'd3;   inj_pld[0] = DW'(16'h0B0B);
    #1;
    chk(inj_rdy[0] == 1'b0, "R5 blocked by through flit", DW'(inj_rdy[0]), '0);
    tick();
    chk(cw_out_vld[0] && cw_out_pld[0] == DW'(16'hEEE1), "R5 through flit keeps slot",
        cw_out_pld[0], DW'(16'hEEE1));
    inj_dst[0] = 3'd0; inj_pld[0] = DW'(16'h0C0C);
    cw_in_pld[0] = DW'(16'hEEE2);
    #1;
    chk(inj_rdy[0] == 1'b1, "R5 other direction free", DW'(inj_rdy[0]), DW'(1));
    tick();
    chk(ccw_out_vld[0] && ccw_out_pld[0] == DW'(16'h0C0C), "R5 injected counter-clockwise",
        ccw_out_pld[0], DW'(16'h0C0C));
    chk(cw_out_vld[0] && cw_out_pld[0] == DW'(16'hEEE2), "R5 clockwise through unaffected",
        cw_out_pld[0], DW'(16'hEEE2));
    idle(); tick();
  endtask

  task automatic t_free();
    idle();
    cw_in_vld[0] = 1'b1; cw_in_dst[0] = 3'(ID); cw_in_pld[0] = DW'(16'hF00F);
    inj_vld[0] = 1'b1;   inj_dst[0] = 3'd4;     inj_pld[0] = DW'(16'h6666);
    #1;
    chk(inj_rdy[0] == 1'b1, "R6 ejected slot reusable", DW'(inj_rdy[0]), DW'(1));
    tick();
    chk(cw_out_vld[0] && cw_out_pld[0] == DW'(16'h6666), "R6 injected into freed slot",
        cw_out_pld[0], DW'(16'h6666));
    chk(ej_cw_vld[0] && ej_cw_pld[0] == DW'(16'hF00F), "R6 arriving flit ejected",
        ej_cw_pld[0], DW'(16'hF00F));
    idle(); tick();
  endtask

  task automatic t_starve();
    logic [DW-1:0] exp_pld;
    string tag;
    idle();
    for (int c = 0; c <= 13; c++) begin
      cw_in_vld[0] = (c <= 11);
      cw_in_dst[0] = 3'd5;
      cw_in_pld[0] = DW'(32'h100 + c);
      inj_vld[0]   = (c <= 8) || (c >= 12);
      inj_dst[0]   = 3'd3;
      inj_pld[0]   = (c <= 8) ? DW'(32'hAA) : DW'(32'hBB);
      #1;
      if (c <= 8 || c >= 12) begin
        tag = (c == 8) ? "R7 forced inject ready" : ((c >= 12) ? "R8 ready after hold drains" : "R5 ready while starved");
        chk(inj_rdy[0] == ((c == 8) || (c == 13)), tag, DW'(inj_rdy[0]), DW'((c == 8) || (c == 13)));
      end
      tick();
      if (c < 8)       exp_pld = DW'(32'h100 + c);
      else if (c == 8) exp_pld = DW'(32'hAA);
      else if (c < 13) exp_pld = DW'(32'h100 + c - 1);
      else             exp_pld = DW'(32'hBB);
      tag = (c == 8) ? "R7 forced inject on ring" : ((c > 8) ? "R8 held stream order" : "R5 through stream");
      chk(cw_out_vld[0] && cw_out_pld[0] == exp_pld, tag, cw_out_pld[0], exp_pld);
    end
    idle(); tick();
    chk(!cw_out_vld[0], "R8 ring empty after drain", DW'(cw_out_vld[0]), '0);
  endtask

  task automatic t_indep();
    idle();
    cw_in_vld[0] = 1'b1; cw_in_dst[0] = 3'd5; cw_in_pld[0] = DW'(16'h1234);
    inj_vld[0] = 1'b1;   inj_dst[0] = 3'd3;   inj_pld[0] = DW'(16'h5555);
    inj_vld[3] = 1'b1;   inj_dst[3] = 3'd3;
    inj_pld[3] = {8{32'hA5C3_0F1E}};
    #1;
    chk(inj_rdy[0] == 1'b0 && inj_rdy[3] == 1'b1, "R1 rings arbitrate separately",
        DW'(inj_rdy), DW'(4'b1000));
    tick();
    chk(cw_out_vld[3] && cw_out_pld[3] == {8{32'hA5C3_0F1E}}, "R1 data ring carries full flit",
        cw_out_pld[3], {8{32'hA5C3_0F1E}});
    chk(cw_out_pld[0] == DW'(16'h1234) && !cw_out_vld[1] && !cw_out_vld[2],
        "R1 other rings undisturbed", cw_out_pld[0], DW'(16'h1234));
    idle(); tick();
  endtask

  task automatic t_width();
    idle();
    inj_vld[2] = 1'b1; inj_dst[2] = 3'd3; inj_pld[2] = '1;
    cw_in_vld[1] = 1'b1; cw_in_dst[1] = 3'd6; cw_in_pld[1] = '1;
    tick();
    chk(cw_out_vld[2] && cw_out_pld[2] == DW'(16'hFFFF), "R10 acknowledge ring width 16",
        cw_out_pld[2], DW'(16'hFFFF));
    chk(cw_out_vld[1] && cw_out_pld[1] == DW'(40'hFF_FFFF_FFFF), "R10 snoop ring width 40",
        cw_out_pld[1], DW'(40'hFF_FFFF_FFFF));
    idle(); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle();
    t_reset();
    t_pass();
    t_eject();
    t_dir();
    t_block();
    t_free();
    t_starve();
    t_indep();
    t_width();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule